// File: doc/BRIEF.md
# Sixteen-Pin I/O Port Register Block with Configuration Freeze

This block is the register side of a general-purpose I/O port. A simple word-addressed bus writes and reads seven registers. Two of them are configuration words, each carrying a 4-bit field for eight pins. One is a synchronized input snapshot, which is read-only. One is the output latch. Two are atomic update ports for the output latch. The last is a freeze register. From each pin's field and its output-latch bit, the block derives the pad controls: drive enable, open-drain select, output level, and pull-up or pull-down enable. Drive speed codes are only stored. Analog pad behaviour and alternate-function routing are outside the block.

A pin field holds a mode in bits [1:0] and a configuration code in bits [3:2]. Mode 00 means input. Any non-zero mode means output, and the mode value is the speed code. For inputs, code 00 is analog, 01 is floating and 10 is pulled. For outputs, code bit 2 selects open-drain and code bit 3 selects the alternate source, which is only stored here. In pulled-input mode the pin's output-latch bit picks the direction: 1 pulls up, 0 pulls down.

Configuration of chosen pins can be frozen until reset. Software writes the freeze register three times with the same 16-bit mask: key bit 16 set, then clear, then set again. It then reads the freeze register. The sequencer has five states:
- **IDLE**: goes to **ARMED** on a freeze write with the key set, and captures the mask.
- **ARMED**: goes to **DIPPED** on a freeze write with the key clear and the same mask.
- **DIPPED**: goes to **REARMED** on a freeze write with the key set and the same mask.
- **REARMED**: goes to **SEALED** on a read of the freeze register.
- **SEALED**: the terminal state.

From ARMED, DIPPED or REARMED, the sequencer falls back to IDLE on any freeze write that does not match, or on any write to another register. Reads of other registers do not disturb the sequence.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every pin field reads 0x4 (floating input), so both configuration words read 0x44444444. The output latch and the freeze register read 0. All pad drive enables and pull enables are 0.
- R2: Pin p's field is read and written at bits [4*(p mod 8)+3 : 4*(p mod 8)]. Pins 0-7 are at address 0 and pins 8-15 at address 1. A non-zero mode (bits [1:0]) raises the pin's drive enable. In that case bit 2 of the field raises its open-drain select.
- R3: The pull controls act only for an input with code 10 (field bits [3:2]). There, the pin's output-latch bit set gives pull-up and clear gives pull-down. Floating, analog and output pins have both pulls at 0.
- R4: A write to address 4 sets latch bit n for each set data bit n, and clears latch bit n for each set data bit n+16. Latch bits whose two data bits are both 0 keep their value. When both are set, the set wins.
- R5: A write to address 5 clears latch bit n for each set data bit n (n < 16), leaves all other latch bits unchanged, and ignores data bits 16-31.
- R6: Pad input levels reach the input register at address 2 through a two-flop synchronizer. A change before clock edge k is readable after edge k+1 and not after edge k. Writes to address 2 have no effect.
- R7: Four accesses to address 6 seal the freeze register: writes of key bit 16 = 1, then 0, then 1, all with the same mask in bits [15:0], followed by a read. After sealing, address 6 reads key 1 with the mask. Configuration writes then leave masked pins' fields unchanged and still update the unmasked fields.
- R8: A broken sequence returns the sequencer to IDLE and leaves nothing frozen. A sequence is broken by a wrong key value, a changed mask, or a write to another register in between.
- R9: Once sealed, the freeze register ignores further writes until reset.
- R10: A write to address 3 loads the output latch from data bits [15:0]. The output latch drives the pad output levels directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_oe | output | NPINS | Per-pin drive enable |
| pad_od | output | NPINS | Per-pin open-drain select |
| pad_out | output | NPINS | Per-pin output level |
| pad_pu | output | NPINS | Per-pin pull-up enable |
| pad_pd | output | NPINS | Per-pin pull-down enable |

## Verification
The bench builds the block with its defaults: sixteen pins and a two-stage synchronizer. With sixteen pins, both configuration words are full. The set and clear halves of the atomic update word also meet exactly at bit 16, so a set and a clear for the same pin can collide in one write. Two stages give an input latency that the bench probes on both sides of the boundary. A partial freeze mask of one pin per configuration word shows frozen and writable fields side by side in each word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W       = 3;
    localparam int DATA_W       = 32;
    localparam int FIELD_W      = 4;
    localparam int PINS_PER_CFG = DATA_W / FIELD_W;
    localparam int KEY_BIT      = 16;
    localparam int CLR_SHIFT    = 16;

    localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_IN     = 3'd2;
    localparam logic [ADDR_W-1:0] A_OUT    = 3'd3;
    localparam logic [ADDR_W-1:0] A_SETCLR = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;
    localparam logic [ADDR_W-1:0] A_LOCK   = 3'd6;

    localparam logic [FIELD_W-1:0] FIELD_RST = 4'h4;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ARMED,
        LK_DIPPED,
        LK_REARMED,
        LK_SEALED
    } lock_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_port_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               latch_bit,
    output logic               oe,
    output logic               od,
    output logic               drv,
    output logic               pu,
    output logic               pd
);
    logic       is_out;
    logic [1:0] code;
    logic       pulled;

    assign is_out = |field[1:0];
    assign code   = field[3:2];
    assign pulled = !is_out && (code == 2'b10);

    assign oe  = is_out;
    assign od  = is_out && code[0];
    assign drv = latch_bit;
    assign pu  = pulled && latch_bit;
    assign pd  = pulled && !latch_bit;
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_wr,
    input  logic             lk_rd,
    input  logic             other_wr,
    input  logic             wr_key,
    input  logic [NPINS-1:0] wr_mask,
    output logic             sealed,
    output logic [NPINS-1:0] frozen_mask
);
    lock_state_e      state_q, state_d;
    logic [NPINS-1:0] held_q;
    logic             capture, seal, same_mask;

    assign same_mask = (wr_mask == held_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        seal    = 1'b0;
        unique case (state_q)
            LK_IDLE: begin
                if (lk_wr && wr_key) begin
                    state_d = LK_ARMED;
                    capture = 1'b1;
                end
            end
            LK_ARMED: begin
                if (other_wr) state_d = LK_IDLE;
                else if (lk_wr) state_d = (!wr_key && same_mask) ? LK_DIPPED : LK_IDLE;
            end
            LK_DIPPED: begin
                if (other_wr) state_d = LK_IDLE;
                else if (lk_wr) state_d = (wr_key && same_mask) ? LK_REARMED : LK_IDLE;
            end
            LK_REARMED: begin
                if (other_wr || lk_wr) state_d = LK_IDLE;
                else if (lk_rd) begin
                    state_d = LK_SEALED;
                    seal    = 1'b1;
                end
            end
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q      <= '0;
            frozen_mask <= '0;
        end else begin
            if (capture) held_q      <= wr_mask;
            if (seal)    frozen_mask <= held_q;
        end
    end

    assign sealed = (state_q == LK_SEALED);

    // R7
    sealed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed);

    // R8
    foreign_write_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (other_wr && state_q != LK_SEALED) |=> (state_q == LK_IDLE));

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> $stable(frozen_mask));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_od,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd
);
    localparam int NCFG = NPINS / PINS_PER_CFG;

    logic [FIELD_W-1:0] cfg_q [NPINS];
    logic [DATA_W-1:0]  cfg_word [NCFG];
    logic [NPINS-1:0]   odr_q, in_q, frozen;
    logic               sealed, lk_wr, lk_rd, other_wr;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:KEY_BIT+1];

    assign lk_wr    = bus_wr && (bus_addr == A_LOCK);
    assign lk_rd    = bus_rd && (bus_addr == A_LOCK);
    assign other_wr = bus_wr && (bus_addr != A_LOCK);

    gpio_lock_seq #(.NPINS(NPINS)) u_lock (
        .clk(clk), .rst_n(rst_n), .lk_wr(lk_wr), .lk_rd(lk_rd),
        .other_wr(other_wr), .wr_key(bus_wdata[KEY_BIT]),
        .wr_mask(bus_wdata[NPINS-1:0]), .sealed(sealed), .frozen_mask(frozen)
    );

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(p / PINS_PER_CFG);
        localparam int                MY_OFS  = (p % PINS_PER_CFG) * FIELD_W;

        always_ff @(posedge clk) begin
            if (!rst_n) cfg_q[p] <= FIELD_RST;
            else if (bus_wr && bus_addr == MY_ADDR && !frozen[p])
                cfg_q[p] <= bus_wdata[MY_OFS +: FIELD_W];
        end

        gpio_pin_drive u_drive (
            .field(cfg_q[p]), .latch_bit(odr_q[p]),
            .oe(pad_oe[p]), .od(pad_od[p]), .drv(pad_out[p]),
            .pu(pad_pu[p]), .pd(pad_pd[p])
        );

        // R7
        frozen_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            frozen[p] |=> $stable(cfg_q[p]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) odr_q <= '0;
        else if (bus_wr) begin
            case (bus_addr)
                A_OUT:    odr_q <= bus_wdata[NPINS-1:0];
                A_SETCLR: odr_q <= (odr_q & ~bus_wdata[CLR_SHIFT +: NPINS]) | bus_wdata[NPINS-1:0];
                A_CLR:    odr_q <= odr_q & ~bus_wdata[NPINS-1:0];
                default:  odr_q <= odr_q;
            endcase
        end
    end

    always_comb begin
        for (int r = 0; r < NCFG; r++)
            for (int k = 0; k < PINS_PER_CFG; k++)
                cfg_word[r][k*FIELD_W +: FIELD_W] = cfg_q[r*PINS_PER_CFG + k];
    end

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NCFG; r++)
            if (bus_addr == ADDR_W'(r)) bus_rdata = cfg_word[r];
        case (bus_addr)
            A_IN:    bus_rdata[NPINS-1:0] = in_q;
            A_OUT:   bus_rdata[NPINS-1:0] = odr_q;
            A_LOCK: begin
                bus_rdata[KEY_BIT]     = sealed;
                bus_rdata[NPINS-1:0]   = frozen;
            end
            default: ;
        endcase
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SETCLR) |=>
            ((odr_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R5
    clr_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR) |=>
            ((odr_q & $past(bus_wdata[NPINS-1:0])) == '0));
endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
    import gpio_port_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr, bus_rd, probe;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic [NP-1:0]     pad_in, pad_oe, pad_od, pad_out, pad_pu, pad_pd;

    gpio_port_regs #(.NPINS(NP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_od(pad_od), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          is_pad;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_vec = 0;
    int    n_bad = 0;

    function automatic logic [31:0] pick_pad(int sel);
        case (sel)
            0: return {16'h0, pad_oe};
            1: return {16'h0, pad_od};
            2: return {16'h0, pad_out};
            3: return {16'h0, pad_pu};
            default: return {16'h0, pad_pd};
        endcase
    endfunction

    // monitor: samples a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (probe) begin
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got %h expected an item", bus_rdata);
            end else begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_pad ? pick_pad(it.sel) : bus_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d; probe = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; probe = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; probe = 1'b1;
        sb.push_back('{1'b0, 0, e, tag});
    endtask

    task automatic expect_pad(input int sel, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; probe = 1'b1;
        sb.push_back('{1'b1, sel, e, tag});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; probe = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(A_CFG_LO, 32'h4444_4444, "R1 cfg lo reset");
        expect_rd(A_CFG_HI, 32'h4444_4444, "R1 cfg hi reset");
        expect_rd(A_OUT, 32'h0, "R1 latch reset");
        expect_rd(A_LOCK, 32'h0, "R1 freeze reset");
        expect_pad(0, 32'h0, "R1 oe reset");
        expect_pad(3, 32'h0, "R1 pu reset, R3 floating");
        expect_pad(4, 32'h0, "R1 pd reset, R3 floating");

        // R2 field placement and decode
        wr(A_CFG_LO, 32'h4444_0851);
        wr(A_CFG_HI, 32'hF444_444B);
        expect_rd(A_CFG_LO, 32'h4444_0851, "R2 cfg lo readback");
        expect_rd(A_CFG_HI, 32'hF444_444B, "R2 cfg hi readback");
        expect_pad(0, 32'h0000_8103, "R2 drive enable");
        expect_pad(1, 32'h0000_8002, "R2 open-drain");
        expect_pad(4, 32'h0000_0004, "R3 pull-down with latch 0");
        expect_pad(3, 32'h0000_0000, "R3 no pull-up with latch 0");

        // R10 direct latch write, R3 pull direction follows latch
        wr(A_OUT, 32'h0000_00A5);
        expect_rd(A_OUT, 32'h0000_00A5, "R10 latch readback");
        expect_pad(2, 32'h0000_00A5, "R10 pad output");
        expect_pad(3, 32'h0000_0004, "R3 pull-up with latch 1");
        expect_pad(4, 32'h0000_0000, "R3 no pull-down with latch 1");

        // R4 atomic set/clear
        wr(A_SETCLR, 32'h0001_0100);
        expect_rd(A_OUT, 32'h0000_01A4, "R4 set bit8 clear bit0");
        wr(A_SETCLR, 32'h0002_0002);
        expect_rd(A_OUT, 32'h0000_01A6, "R4 set wins over clear");

        // R5 clear-only port
        wr(A_CLR, 32'hFFFF_0180);
        expect_rd(A_OUT, 32'h0000_0026, "R5 clear bits 7,8");

        // R6 synchronizer latency and read-only input register
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; probe = 1'b0; pad_in = 16'h5A3C;
        expect_rd(A_IN, 32'h0, "R6 not yet visible after one edge");
        expect_rd(A_IN, 32'h0000_5A3C, "R6 visible after two edges");
        wr(A_IN, 32'h0000_FFFF);
        expect_rd(A_IN, 32'h0000_5A3C, "R6 write to input ignored");

        // R8 broken by changed mask
        wr(A_LOCK, 32'h0001_0003);
        wr(A_LOCK, 32'h0000_0003);
        wr(A_LOCK, 32'h0001_0007);
        expect_rd(A_LOCK, 32'h0, "R8 mask change read");
        expect_rd(A_LOCK, 32'h0, "R8 mask change not sealed");
        wr(A_CFG_LO, 32'h2222_2222);
        expect_rd(A_CFG_LO, 32'h2222_2222, "R8 pins still writable");

        // R8 broken by a foreign write
        wr(A_LOCK, 32'h0001_0003);
        wr(A_LOCK, 32'h0000_0003);
        wr(A_OUT, 32'h0000_0026);
        wr(A_LOCK, 32'h0001_0003);
        expect_rd(A_LOCK, 32'h0, "R8 foreign write read");
        expect_rd(A_LOCK, 32'h0, "R8 foreign write not sealed");
        wr(A_CFG_LO, 32'h1111_1111);
        expect_rd(A_CFG_LO, 32'h1111_1111, "R8 pins writable after foreign break");

        // R7 proper sequence
        wr(A_LOCK, 32'h0001_0101);
        wr(A_LOCK, 32'h0000_0101);
        wr(A_LOCK, 32'h0001_0101);
        expect_rd(A_LOCK, 32'h0, "R7 sealing read");
        expect_rd(A_LOCK, 32'h0001_0101, "R7 key and mask after seal");
        wr(A_CFG_LO, 32'h2222_2222);
        wr(A_CFG_HI, 32'h3333_3333);
        expect_rd(A_CFG_LO, 32'h2222_2221, "R7 pin0 frozen");
        expect_rd(A_CFG_HI, 32'h3333_333B, "R7 pin8 frozen");

        // R9 sealed register ignores writes
        wr(A_LOCK, 32'h0001_FFFF);
        wr(A_LOCK, 32'h0000_FFFF);
        wr(A_LOCK, 32'h0001_FFFF);
        expect_rd(A_LOCK, 32'h0001_0101, "R9 freeze read unchanged");
        wr(A_CFG_LO, 32'h4444_4444);
        expect_rd(A_CFG_LO, 32'h4444_4441, "R9 mask not widened");

        idle();
        idle();
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard leftover: got %0d expected 0", sb.size());
        end
        summary();
        $finish;
    end
endmodule